// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Resolver

This block sits in front of an iterative mantissa divider. It looks only at the class code and the sign of the dividend (operand A) and of the divisor (operand B). From these it decides the whole result when the answer follows from the operand classes alone: a NaN, an infinity or a zero. In those cases it also sets the exception flags. When both operands are ordinary finite nonzero numbers it does not form a result. Instead it raises a dispatch request so that the divider computes the quotient.

The block is purely combinational. A surrounding pipeline registers its outputs as it sees fit. The block decides in a fixed order:
1. NaNs.
2. A special dividend.
3. A special divisor.

The payload-source output tells the datapath which operand's significand and exponent travel to the result. A code of none means the datapath builds a canonical value itself.

Class code encoding, used on both inputs and on the result: 0 = zero, 1 = normal, 2 = infinity, 3 = quiet NaN, 4 = signalling NaN. Codes 5 to 7 are unused.

Payload-source encoding: 0 = none, 1 = dividend, 2 = divisor.

Top module: `fpdiv_special_resolver`

## Requirements
- R1: Input class codes 5, 6 and 7 behave exactly as code 3 (quiet NaN) does, on both operands.
- R2: If either operand is a NaN, `res_valid` is 1 and `res_class` is 3 (quiet NaN). `res_sign` is the sign of the propagated operand, and neither flag is raised.
- R3: When exactly one operand is a signalling NaN (code 4), that operand is propagated: `payload_src` is 1 for the dividend and 2 for the divisor.
- R4: When only one operand is a NaN, that operand is propagated. When both are NaNs of the same kind (both quiet or both signalling), the divisor is propagated (`payload_src` = 2).
- R5: Infinity divided by infinity, and zero divided by zero, give a fresh NaN. This means `res_class` = 3, `res_sign` = 0, `payload_src` = 0 and `flag_invalid` = 1.
- R6: A dividend that is infinity or zero, over a divisor of another non-NaN class, returns the dividend unchanged. This means its class, its own sign, `payload_src` = 1 and no flags.
- R7: A normal dividend over an infinite divisor gives zero (`res_class` = 0) with sign A XOR B, `payload_src` = 0 and no flags.
- R8: A normal dividend over a zero divisor gives infinity (`res_class` = 2) with sign A XOR B, `payload_src` = 0 and `flag_divzero` = 1.
- R9: A normal dividend over a normal divisor sets `dispatch` = 1 and `res_valid` = 0. It also drives `res_class` = 1 with sign A XOR B, `payload_src` = 0 and no flags.
- R10: For every input, exactly one of `res_valid` and `dispatch` is 1, and at most one of the two flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_class | input | 3 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| b_class | input | 3 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| res_class | output | 3 | Result class code |
| res_sign | output | 1 | Result sign |
| payload_src | output | 2 | Operand whose payload is forwarded (0 none, 1 dividend, 2 divisor) |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_divzero | output | 1 | Divide-by-zero exception |
| res_valid | output | 1 | Result fully decided here |
| dispatch | output | 1 | Start the mantissa divider |

## Verification
The input space is small enough to cover completely. The hard part is the NaN tie-break when both operands are NaNs: same kind, mixed kind, and the unused codes that must quietly count as quiet NaNs. Near-identical encodings make an off-by-one in the priority easy to miss. The stimulus therefore sweeps every pairing of all eight codes on each side with all four sign combinations, so every tie-break and every alias is reached. Named directed vectors are then added for each priority step.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  localparam int CLASS_W = 3;
  localparam int SRC_W   = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } payload_src_e;

  typedef struct packed {
    logic zero;
    logic norm;
    logic inf;
    logic nan;
    logic snan;
  } class_bits_t;

  // Map a raw code onto the canonical class; spare codes fold to quiet NaN.
  function automatic fp_class_e canon_class(input logic [CLASS_W-1:0] raw);
    fp_class_e c;
    case (raw)
      3'd0:    c = CLS_ZERO;
      3'd1:    c = CLS_NORM;
      3'd2:    c = CLS_INF;
      3'd4:    c = CLS_SNAN;
      default: c = CLS_QNAN;
    endcase
    return c;
  endfunction

  // Dividend wins the NaN contest only if it is the sole NaN or the sole
  // signalling NaN; every tie goes to the divisor.
  function automatic logic nan_prefers_dividend(input class_bits_t a,
                                                input class_bits_t b);
    return a.nan && (!b.nan || (a.snan && !b.snan));
  endfunction

endpackage

// File: rtl/fpdiv_class_decode.sv
module fpdiv_class_decode
  import fpdiv_pkg::*;
#(
  parameter int CW = CLASS_W
) (
  input  logic [CW-1:0] code,
  output class_bits_t   bits
);
  fp_class_e c;

  always_comb begin
    c         = canon_class(code);
    bits.zero = (c == CLS_ZERO);
    bits.norm = (c == CLS_NORM);
    bits.inf  = (c == CLS_INF);
    bits.snan = (c == CLS_SNAN);
    bits.nan  = (c == CLS_QNAN) || (c == CLS_SNAN);
  end
endmodule

// File: rtl/fpdiv_nan_pick.sv
module fpdiv_nan_pick
  import fpdiv_pkg::*;
(
  input  class_bits_t a_bits,
  input  class_bits_t b_bits,
  output logic        any_nan,
  output logic        pick_a
);
  assign any_nan = a_bits.nan | b_bits.nan;
  assign pick_a  = nan_prefers_dividend(a_bits, b_bits);
endmodule

// File: rtl/fpdiv_special_sel.sv
module fpdiv_special_sel
  import fpdiv_pkg::*;
(
  input  class_bits_t           a_bits,
  input  class_bits_t           b_bits,
  input  logic                  a_sign,
  input  logic                  b_sign,
  input  logic                  any_nan,
  input  logic                  pick_a,
  output logic [CLASS_W-1:0]    res_class,
  output logic                  res_sign,
  output logic [SRC_W-1:0]      payload_src,
  output logic                  flag_invalid,
  output logic                  flag_divzero,
  output logic                  res_valid,
  output logic                  dispatch
);
  logic xsign;
  logic a_special;
  logic same_special;

  assign xsign        = a_sign ^ b_sign;
  assign a_special    = a_bits.inf | a_bits.zero;
  assign same_special = (a_bits.inf & b_bits.inf) | (a_bits.zero & b_bits.zero);

  always_comb begin
    res_class    = CLS_NORM;
    res_sign     = xsign;
    payload_src  = SRC_NONE;
    flag_invalid = 1'b0;
    flag_divzero = 1'b0;
    res_valid    = 1'b1;
    dispatch     = 1'b0;
    if (any_nan) begin
      res_class   = CLS_QNAN;
      res_sign    = pick_a ? a_sign : b_sign;
      payload_src = pick_a ? SRC_A : SRC_B;
    end else if (a_special) begin
      if (same_special) begin
        res_class    = CLS_QNAN;
        res_sign     = 1'b0;
        flag_invalid = 1'b1;
      end else begin
        res_class   = a_bits.inf ? CLS_INF : CLS_ZERO;
        res_sign    = a_sign;
        payload_src = SRC_A;
      end
    end else if (b_bits.inf) begin
      res_class = CLS_ZERO;
    end else if (b_bits.zero) begin
      res_class    = CLS_INF;
      flag_divzero = 1'b1;
    end else begin
      res_valid = 1'b0;
      dispatch  = 1'b1;
    end
  end
endmodule

// File: rtl/fpdiv_special_resolver.sv
module fpdiv_special_resolver
  import fpdiv_pkg::*;
(
  input  logic [2:0] a_class,
  input  logic       a_sign,
  input  logic [2:0] b_class,
  input  logic       b_sign,
  output logic [2:0] res_class,
  output logic       res_sign,
  output logic [1:0] payload_src,
  output logic       flag_invalid,
  output logic       flag_divzero,
  output logic       res_valid,
  output logic       dispatch
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][CLASS_W-1:0] op_code;
  class_bits_t                  op_bits [NOPS];
  class_bits_t                  a_bits;
  class_bits_t                  b_bits;
  logic                         any_nan;
  logic                         pick_a;

  assign op_code[0] = a_class;
  assign op_code[1] = b_class;

  for (genvar i = 0; i < NOPS; i++) begin : g_dec
    fpdiv_class_decode #(.CW(CLASS_W)) u_dec (
      .code (op_code[i]),
      .bits (op_bits[i])
    );
  end

  assign a_bits = op_bits[0];
  assign b_bits = op_bits[1];

  fpdiv_nan_pick u_nan (
    .a_bits  (a_bits),
    .b_bits  (b_bits),
    .any_nan (any_nan),
    .pick_a  (pick_a)
  );

  fpdiv_special_sel u_sel (
    .a_bits       (a_bits),
    .b_bits       (b_bits),
    .a_sign       (a_sign),
    .b_sign       (b_sign),
    .any_nan      (any_nan),
    .pick_a       (pick_a),
    .res_class    (res_class),
    .res_sign     (res_sign),
    .payload_src  (payload_src),
    .flag_invalid (flag_invalid),
    .flag_divzero (flag_divzero),
    .res_valid    (res_valid),
    .dispatch     (dispatch)
  );
endmodule

// File: rtl/fpdiv_resolver_chk.sv
module fpdiv_resolver_chk (
  input logic [2:0] a_class,
  input logic [2:0] b_class,
  input logic [2:0] res_class,
  input logic [1:0] payload_src,
  input logic       flag_invalid,
  input logic       flag_divzero,
  input logic       res_valid,
  input logic       dispatch,
  input logic       any_nan,
  input logic       pick_a
);
  always_comb begin
    // R10
    one_outcome_chk: assert (res_valid ^ dispatch);
    // R10
    one_flag_chk: assert (!(flag_invalid && flag_divzero));
    // R9
    dispatch_normals_chk: assert (!dispatch || (a_class == 3'd1 && b_class == 3'd1));
    // R2
    nan_result_chk: assert (!any_nan || (res_class == 3'd3 && !flag_invalid && !flag_divzero));
    // R3
    nan_src_chk: assert (!any_nan || payload_src == (pick_a ? 2'd1 : 2'd2));
    // R5
    invalid_fresh_chk: assert (!flag_invalid || (payload_src == 2'd0 && res_class == 3'd3));
    // R8
    divzero_chk: assert (!flag_divzero || (b_class == 3'd0 && res_class == 3'd2));
  end
endmodule

bind fpdiv_special_resolver fpdiv_resolver_chk u_chk (
  .a_class      (a_class),
  .b_class      (b_class),
  .res_class    (res_class),
  .payload_src  (payload_src),
  .flag_invalid (flag_invalid),
  .flag_divzero (flag_divzero),
  .res_valid    (res_valid),
  .dispatch     (dispatch),
  .any_nan      (any_nan),
  .pick_a       (pick_a)
);

// File: tb/fpdiv_special_resolver_bench.sv
module fpdiv_special_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] a_class = 3'd0, b_class = 3'd0;
  logic       a_sign = 1'b0, b_sign = 1'b0;
  logic [2:0] res_class;
  logic       res_sign, flag_invalid, flag_divzero, res_valid, dispatch;
  logic [1:0] payload_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fpdiv_special_resolver u_fpdiv_special_resolver (
    .a_class(a_class), .a_sign(a_sign), .b_class(b_class), .b_sign(b_sign),
    .res_class(res_class), .res_sign(res_sign), .payload_src(payload_src),
    .flag_invalid(flag_invalid), .flag_divzero(flag_divzero),
    .res_valid(res_valid), .dispatch(dispatch));

  // Reference: packed expectation {class, sign, src, inv, dz, valid, disp}
  function automatic int kind(input int c);  // 0 zero 1 norm 2 inf 3 qnan 4 snan
    if (c >= 5) return 3;
    return c;
  endfunction

  task automatic expect_of(input int ac, input int as, input int bc, input int bs,
                           output logic [9:0] e, output string req);
    int ka = kind(ac), kb = kind(bc);
    bit an = (ka >= 3), bn = (kb >= 3);
    int cls = 1, sg = as ^ bs, src = 0, inv = 0, dz = 0, vld = 1, dsp = 0;
    req = "R9";
    if (an || bn) begin
      bit take_a;
      if (an && !bn) take_a = 1;
      else if (bn && !an) take_a = 0;
      else take_a = (ka == 4 && kb == 3);
      cls = 3; sg = take_a ? as : bs; src = take_a ? 1 : 2;
      req = (ac >= 5 || bc >= 5) ? "R1" : ((ka == 4) != (kb == 4)) ? "R3" : (an && bn) ? "R4" : "R2";
    end else if (ka == 0 || ka == 2) begin
      if (ka == kb) begin cls = 3; sg = 0; inv = 1; req = "R5"; end
      else begin cls = ka; sg = as; src = 1; req = "R6"; end
    end else if (kb == 2) begin cls = 0; req = "R7"; end
    else if (kb == 0) begin cls = 2; dz = 1; req = "R8"; end
    else begin vld = 0; dsp = 1; end
    e = {cls[2:0], sg[0], src[1:0], inv[0], dz[0], vld[0], dsp[0]};
  endtask

  task automatic apply_and_check(input int ac, input int as, input int bc, input int bs);
    logic [9:0] exp_v, got;
    string req;
    @(posedge clk); #1;
    a_class = ac[2:0]; a_sign = as[0]; b_class = bc[2:0]; b_sign = bs[0];
    @(negedge clk);
    expect_of(ac, as, bc, bs, exp_v, req);
    got = {res_class, res_sign, payload_src, flag_invalid, flag_divzero, res_valid, dispatch};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s a=%0d/%0d b=%0d/%0d got=%b exp=%b", req, ac, as, bc, bs, got, exp_v);
    end
    // R10 exclusivity checked on every vector
    checks++;
    if ((res_valid ^ dispatch) !== 1'b1 || (flag_invalid & flag_divzero) !== 1'b0) begin
      fails++;
      $display("FAIL R10 got valid=%b disp=%b inv=%b dz=%b exp one-hot", res_valid, dispatch, flag_invalid, flag_divzero);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // reset state: zero/zero inputs -> fresh NaN (R5)
    @(negedge clk);
    checks++;
    if ({res_class, payload_src, flag_invalid, res_valid} !== {3'd3, 2'd0, 1'b1, 1'b1}) begin
      fails++;
      $display("FAIL R5 reset got=%b exp=%b", {res_class, payload_src, flag_invalid, res_valid}, 7'b0110011);
    end
    rst_n = 1'b1;
    // directed points per priority step
    apply_and_check(4, 1, 3, 0);  // R3 sNaN dividend beats qNaN divisor
    apply_and_check(3, 0, 4, 1);  // R3
    apply_and_check(4, 0, 4, 1);  // R4 tie -> divisor
    apply_and_check(6, 1, 1, 0);  // R1 spare code as NaN
    apply_and_check(2, 1, 2, 0);  // R5
    apply_and_check(2, 1, 0, 0);  // R6 inf/0 keeps inf, no dz
    apply_and_check(0, 1, 1, 0);  // R6
    apply_and_check(1, 1, 2, 0);  // R7
    apply_and_check(1, 0, 0, 1);  // R8
    apply_and_check(1, 1, 1, 1);  // R9
    // exhaustive sweep: every code pair, every sign pair (R1..R10)
    for (int ac = 0; ac < 8; ac++)
      for (int bc = 0; bc < 8; bc++)
        for (int s = 0; s < 4; s++)
          apply_and_check(ac, s >> 1, bc, s & 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=timeout exp=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule